// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits between two processor request ports and a single shared word-addressed memory. It carries out plain reads and writes, and three indivisible operations: test-and-set, compare-and-swap and a 16-bit interlocked add. It handles one request at a time. For every atomic operation it holds a lock signal from the memory read cycle through the write-back cycle, so no other access reaches the memory in that window.

Each port raises `req` and holds its opcode, address and two operands until its `done` bit pulses. The answer appears on a response bus that both ports share. It carries the old memory word, the value the requester should load into its compare register, four condition flags and an error bit. When both ports request in the same cycle, port 0 is served first, and port 1 keeps its request held until its turn comes.

Top module: `atom_rmw_unit`

## Requirements
- R1: Opcodes are 0 = read, 1 = write, 2 = test-and-set, 3 = compare-and-swap and 4 = interlocked add. A read returns the stored word. A write stores `opa`. Both leave the flags at 0, and a write returns 0 as its data.
- R2: Test-and-set returns the old word. It sets flag N (bit 3) from the old word's top bit and flag Z (bit 2) when the old word is zero. It writes back the old word with only its top bit forced to 1.
- R3: Compare-and-swap with the memory word equal to `opa` writes `opb` to memory. It returns the old word, sets Z and clears the other flags, and returns `opa` on `rsp_cmp`.
- R4: Compare-and-swap with the memory word not equal to `opa` leaves memory unchanged and clears Z. It returns the memory word on both `rsp_data` and `rsp_cmp`.
- R5: Interlocked add writes (old + `opa`) modulo 2^16 and returns the old word. The flags come from the sum: N = bit 3, Z = bit 2, V (signed overflow) = bit 1, C (carry out) = bit 0.
- R6: An interlocked add with address bit 0 set answers with `rsp_err` = 1 and zero data and flags. It never locks and leaves memory unchanged.
- R7: When both ports request in the same cycle, port 0 is served first. Port 1 is then served with its held request, starting right after port 0's response.
- R8: `lock` is high for exactly two consecutive cycles in every atomic operation. It is never high for a plain read, a plain write or a rejected add.
- R9: `done` is one-hot and lasts one cycle. It pulses 3 cycles after acceptance for reads and atomic operations, 2 cycles after for writes and 1 cycle after for a rejected add.
- R10: After a synchronous active-low reset, `done`, `lock`, `rsp_data`, `rsp_cmp`, `rsp_flags` and `rsp_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NP | Request per port, held until that port's done |
| op_i | input | 3*NP | Opcode per port |
| addr_i | input | AW*NP | Word address per port |
| opa_i | input | DW*NP | Write data, compare value or addend |
| opb_i | input | DW*NP | Swap value for compare-and-swap |
| done_o | output | NP | One-cycle completion pulse for the port served |
| rsp_data_o | output | DW | Old memory word |
| rsp_cmp_o | output | DW | New compare-register value after compare-and-swap |
| rsp_flags_o | output | 4 | N, Z, V, C from bit 3 down to bit 0 |
| rsp_err_o | output | 1 | Misaligned interlocked add rejected |
| lock_o | output | 1 | Memory lock held across the read and write cycles |

## Verification
Two requests can arrive in the same cycle: an interlocked add on port 0 and a test-and-set on port 1, both aimed at the same word. The bench raises both in one cycle. It then checks that port 0 completes first and sees the original word. It also checks that port 1 completes exactly four cycles later and sees the sum written by port 0. A final read confirms the word carries both updates. This shows that the loser waited and that the two sequences did not interleave.

// File: rtl/atom_pkg.sv
// Shared types for the atomic read-modify-write unit.
// Assumes a 3-bit opcode field on every request port.
package atom_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_TAS   = 3'd2,
        OP_CAS   = 3'd3,
        OP_ADD   = 3'd4
    } op_e;

    localparam int FLAG_W = 4;

    // True for the operations that need a locked read-then-write.
    function automatic logic is_atomic(op_e o);
        return (o == OP_TAS) || (o == OP_CAS) || (o == OP_ADD);
    endfunction
endpackage

// File: rtl/atom_arb.sv
// Fixed-priority arbiter. The lowest-numbered requesting port wins.
// Assumes requests are held until they are served. Purely combinational.
module atom_arb #(
    parameter int NP = 2,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [IW-1:0] idx
);
    // Scan the ports from 0 upward and grant the first one requesting.
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        idx   = '0;
        for (int i = 0; i < NP; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                idx    = IW'(i);
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/atom_alu.sv
// Result unit. Given the old memory word and the request operands, it
// produces the write enable, the write value, the flags and the new
// compare value. Assumes the old word is valid when its output is used.
module atom_alu
    import atom_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e                 op,
    input  logic [DW-1:0]       old_word,
    input  logic [DW-1:0]       opa,
    input  logic [DW-1:0]       opb,
    output logic                we,
    output logic [DW-1:0]       wdata,
    output logic [FLAG_W-1:0]   flags,
    output logic [DW-1:0]       cmp_out
);
    logic [DW:0] sum;
    logic        match;

    // Full-width sum and equality compare, shared by the cases below.
    always_comb begin
        sum   = {1'b0, old_word} + {1'b0, opa};
        match = (old_word == opa);
    end

    // Select the write-back value and the flags for each opcode.
    always_comb begin
        we      = 1'b0;
        wdata   = old_word;
        flags   = '0;
        cmp_out = '0;
        unique case (op)
            OP_WRITE: begin
                we    = 1'b1;
                wdata = opa;
            end
            OP_TAS: begin
                we            = 1'b1;
                wdata[DW-1]   = 1'b1;
                flags         = {old_word[DW-1], (old_word == '0), 2'b00};
            end
            OP_CAS: begin
                we      = match;
                wdata   = opb;
                flags   = {1'b0, match, 2'b00};
                cmp_out = match ? opa : old_word;
            end
            OP_ADD: begin
                we    = 1'b1;
                wdata = sum[DW-1:0];
                flags = {sum[DW-1],
                         (sum[DW-1:0] == '0),
                         (old_word[DW-1] == opa[DW-1]) && (sum[DW-1] != old_word[DW-1]),
                         sum[DW]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/atom_mem.sv
// Single-port word memory. Reads are registered, so data arrives one
// cycle after the read enable. A write in the same cycle lands in the array.
module atom_mem #(
    parameter int DW = 16,
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store the write data and register the read data.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/atom_rmw_unit.sv
// Atomic read-modify-write unit. Serves one port at a time through the
// sequence IDLE -> RD -> MOD -> RESP, or IDLE -> WB -> RESP for a plain
// write. lock is held in RD and MOD for atomic operations. Assumes each
// requester holds its fields steady until its done pulse.
module atom_rmw_unit
    import atom_pkg::*;
#(
    parameter int NP = 2,
    parameter int DW = 16,
    parameter int AW = 6,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        req_i,
    input  logic [3*NP-1:0]      op_i,
    input  logic [AW*NP-1:0]     addr_i,
    input  logic [DW*NP-1:0]     opa_i,
    input  logic [DW*NP-1:0]     opb_i,
    output logic [NP-1:0]        done_o,
    output logic [DW-1:0]        rsp_data_o,
    output logic [DW-1:0]        rsp_cmp_o,
    output logic [FLAG_W-1:0]    rsp_flags_o,
    output logic                 rsp_err_o,
    output logic                 lock_o
);
    typedef enum logic [2:0] {S_IDLE, S_RD, S_MOD, S_WB, S_RESP} st_e;

    st_e            st;
    logic [IW-1:0]  sel;
    op_e            cur_op;
    logic [AW-1:0]  cur_addr;
    logic [DW-1:0]  cur_a, cur_b;

    logic [NP-1:0]  arb_gnt;
    logic [IW-1:0]  arb_idx;
    op_e            win_op;
    logic [AW-1:0]  win_addr;
    logic [DW-1:0]  win_a, win_b;

    logic [DW-1:0]  mem_rdata, mem_wdata, alu_cmp;
    logic [FLAG_W-1:0] alu_flags;
    logic           alu_we, mem_we, mem_re;

    atom_arb #(.NP(NP)) u_arb (.req(req_i), .gnt(arb_gnt), .idx(arb_idx));

    // Pick out the winning port's request fields.
    always_comb begin
        win_op   = op_e'(op_i[arb_idx*3 +: 3]);
        win_addr = addr_i[arb_idx*AW +: AW];
        win_a    = opa_i[arb_idx*DW +: DW];
        win_b    = opb_i[arb_idx*DW +: DW];
    end

    // Sequencer: accept a request, then step through its cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            sel      <= '0;
            cur_op   <= OP_READ;
            cur_addr <= '0;
            cur_a    <= '0;
            cur_b    <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (|req_i) begin
                    sel      <= arb_idx;
                    cur_op   <= win_op;
                    cur_addr <= win_addr;
                    cur_a    <= win_a;
                    cur_b    <= win_b;
                    if (win_op == OP_ADD && win_addr[0]) st <= S_RESP;
                    else if (win_op == OP_WRITE)         st <= S_WB;
                    else                                 st <= S_RD;
                end
                S_RD:          st <= S_MOD;
                S_MOD, S_WB:   st <= S_RESP;
                S_RESP:        st <= S_IDLE;
                default:       st <= S_IDLE;
            endcase
        end
    end

    atom_alu #(.DW(DW)) u_alu (
        .op(cur_op), .old_word(mem_rdata), .opa(cur_a), .opb(cur_b),
        .we(alu_we), .wdata(mem_wdata), .flags(alu_flags), .cmp_out(alu_cmp)
    );

    // Memory strobes: read in RD, write in MOD or WB when the result unit asks.
    always_comb begin
        mem_re = (st == S_RD);
        mem_we = ((st == S_MOD) || (st == S_WB)) && alu_we;
    end

    atom_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .re(mem_re), .we(mem_we), .addr(cur_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // Response registers, loaded on the way into RESP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_o  <= '0;
            rsp_cmp_o   <= '0;
            rsp_flags_o <= '0;
            rsp_err_o   <= 1'b0;
        end else if (st == S_MOD) begin
            rsp_data_o  <= mem_rdata;
            rsp_cmp_o   <= alu_cmp;
            rsp_flags_o <= alu_flags;
            rsp_err_o   <= 1'b0;
        end else if (st == S_WB || (st == S_IDLE && |req_i && win_op == OP_ADD && win_addr[0])) begin
            rsp_data_o  <= '0;
            rsp_cmp_o   <= '0;
            rsp_flags_o <= '0;
            rsp_err_o   <= (st == S_IDLE);
        end
    end

    // Completion pulse and lock window.
    always_comb begin
        done_o = '0;
        if (st == S_RESP) done_o[sel] = 1'b1;
        lock_o = ((st == S_RD) || (st == S_MOD)) && is_atomic(cur_op);
    end

    // R9: at most one port completes in a cycle.
    a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));
    // R7: the grant is one-hot and only goes to a requesting port.
    a_r7_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> ($onehot0(arb_gnt) && ((arb_gnt & ~req_i) == '0)));
    // R8: a lock lasts at least into the next cycle.
    a_r8_lock_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |=> lock_o);
    // R8: the lock ends as the response is given.
    a_r8_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> (|done_o));
    // R6: a misaligned add never writes memory.
    a_r6_no_misaligned_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(cur_op == OP_ADD && cur_addr[0]));
    // R2: test-and-set changes only the top bit of the word it read.
    a_r2_tas_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_op == OP_TAS) |->
            (mem_wdata[DW-1] && (mem_wdata[DW-2:0] == mem_rdata[DW-2:0])));
endmodule

// File: tb/atom_rmw_unit_tb.sv
module atom_rmw_unit_tb;
    localparam int NP = 2;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int NV = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req = '0;
    logic [3*NP-1:0]  op = '0;
    logic [AW*NP-1:0] addr = '0;
    logic [DW*NP-1:0] opa = '0, opb = '0;
    logic [NP-1:0]    done;
    logic [DW-1:0]    rsp_data, rsp_cmp;
    logic [3:0]       rsp_flags;
    logic             rsp_err, lock;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    atom_rmw_unit #(.NP(NP), .DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
        .opa_i(opa), .opb_i(opb), .done_o(done), .rsp_data_o(rsp_data),
        .rsp_cmp_o(rsp_cmp), .rsp_flags_o(rsp_flags), .rsp_err_o(rsp_err),
        .lock_o(lock)
    );

    // Each entry: op, addr, opa, opb, exp data, exp cmp, exp flags, exp err.
    localparam logic [77:0] VEC [NV] = '{
        {3'd1, 6'd4, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b0},
        {3'd2, 6'd4, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'b0100, 1'b0},
        {3'd2, 6'd4, 16'h0000, 16'h0000, 16'h8000, 16'h0000, 4'b1000, 1'b0},
        {3'd0, 6'd4, 16'h0000, 16'h0000, 16'h8000, 16'h0000, 4'b0000, 1'b0},
        {3'd3, 6'd4, 16'h8000, 16'h1234, 16'h8000, 16'h8000, 4'b0100, 1'b0},
        {3'd3, 6'd4, 16'h8000, 16'h5555, 16'h1234, 16'h1234, 4'b0000, 1'b0},
        {3'd0, 6'd4, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 4'b0000, 1'b0},
        {3'd1, 6'd6, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b0},
        {3'd4, 6'd6, 16'h0001, 16'h0000, 16'h7FFF, 16'h0000, 4'b1010, 1'b0},
        {3'd4, 6'd6, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 4'b0111, 1'b0},
        {3'd4, 6'd6, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 4'b1000, 1'b0},
        {3'd1, 6'd7, 16'h00AA, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b0},
        {3'd4, 6'd7, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b1},
        {3'd0, 6'd7, 16'h0000, 16'h0000, 16'h00AA, 16'h0000, 4'b0000, 1'b0},
        {3'd0, 6'd6, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 4'b0000, 1'b0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Tag naming the requirement that covers each opcode.
    function automatic string tag_of(input logic [2:0] o, input logic e, input logic [15:0] d);
        if (e) return "R6";
        case (o)
            3'd2: return "R2";
            3'd3: return (d == 16'h8000) ? "R3" : "R4";
            3'd4: return "R5";
            default: return "R1";
        endcase
    endfunction

    // Issue one request on port p and wait for its done; counts lock cycles.
    task automatic run_op(input int p, input logic [2:0] o, input logic [AW-1:0] a,
                          input logic [DW-1:0] va, input logic [DW-1:0] vb,
                          output int waits, output int locks);
        waits = 0;
        locks = 0;
        @(negedge clk);
        op[p*3 +: 3]    = o;
        addr[p*AW +: AW] = a;
        opa[p*DW +: DW]  = va;
        opb[p*DW +: DW]  = vb;
        req[p] = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            waits++;
            if (lock) locks++;
            if (done[p]) break;
        end
        req[p] = 1'b0;
        if (!done[p]) check("R9", "done never seen", 0, 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w, l;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        check("R10", "done", 32'(done), 0);
        check("R10", "lock", 32'(lock), 0);
        check("R10", "rsp_data", 32'(rsp_data), 0);
        check("R10", "rsp_flags", 32'(rsp_flags), 0);
        check("R10", "rsp_err", 32'(rsp_err), 0);

        // Table walk on port 0.
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  vo;
            logic [5:0]  va;
            logic [15:0] vopa, vopb, edata, ecmp;
            logic [3:0]  eflg;
            logic        eerr;
            string       tg;
            int          ew, el;
            {vo, va, vopa, vopb, edata, ecmp, eflg, eerr} = VEC[i];
            tg = tag_of(vo, eerr, vopa);
            run_op(0, vo, va, vopa, vopb, w, l);
            check(tg, "rsp_data", 32'(rsp_data), 32'(edata));
            check(tg, "rsp_cmp", 32'(rsp_cmp), 32'(ecmp));
            check(tg, "rsp_flags", 32'(rsp_flags), 32'(eflg));
            check(tg, "rsp_err", 32'(rsp_err), 32'(eerr));
            ew = eerr ? 1 : ((vo == 3'd1) ? 2 : 3);
            el = (!eerr && vo >= 3'd2 && vo <= 3'd4) ? 2 : 0;
            check("R9", "latency", 32'(w), 32'(ew));
            check("R8", "lock cycles", 32'(l), 32'(el));
        end

        // R7: same-cycle requests to one word from both ports.
        run_op(1, 3'd1, 6'd10, 16'h0002, 16'h0000, w, l);
        begin
            int t0, t1;
            logic [15:0] d0, d1;
            logic [3:0]  f1;
            t0 = -1; t1 = -1; d0 = '0; d1 = '0; f1 = '0;
            @(negedge clk);
            op = {3'd2, 3'd4};
            addr = {6'd10, 6'd10};
            opa = {16'h0000, 16'h0002};
            opb = '0;
            req = 2'b11;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (done[0] && t0 < 0) begin t0 = k; d0 = rsp_data; req[0] = 1'b0; end
                if (done[1] && t1 < 0) begin t1 = k; d1 = rsp_data; f1 = rsp_flags; req[1] = 1'b0; end
                if (t0 >= 0 && t1 >= 0) break;
            end
            req = '0;
            check("R7", "port0 first latency", 32'(t0), 3);
            check("R7", "port1 served 4 after", 32'(t1), 32'(t0 + 4));
            check("R7", "port0 old word", 32'(d0), 32'h0002);
            check("R7", "port1 sees sum", 32'(d1), 32'h0004);
            check("R2", "port1 flags", 32'(f1), 0);
        end
        run_op(1, 3'd0, 6'd10, 16'h0000, 16'h0000, w, l);
        check("R7", "final word", 32'(rsp_data), 32'h8004);

        // R10: reset after activity clears the response.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "rsp_data after reset", 32'(rsp_data), 0);
        check("R10", "done after reset", 32'(done), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule